// File: doc/BRIEF.md
# Programmable TDM Audio Frame Transmitter

This block turns a stream of parallel audio words into a time-division multiplexed serial line. It drives serial data, a data-enable qualifier and a frame sync, and it advances one bit position every time the bit-clock tick input is high. The block always acts as the timing master of the frame. The bit clock itself is generated elsewhere, and the tick marks the edge on which data changes. A receiver samples on the opposite edge of the bit clock.

The frame shape comes from configuration inputs. These set the number of word slots per frame, a separate width for slot 0 and a common width for all other slots, and the length of the sync pulse. They also select sync polarity, an option that starts the sync one bit period early, MSB-first or LSB-first shifting, and the bit of the 32-bit data word that is sent first. A per-slot mask keeps chosen slots silent. A marker output flags the first bit of one chosen slot. A sticky error flag records any unmasked slot that found no word ready to send. Configuration is expected to change only while reset is asserted.

Top module: `tdm_frame_tx`

## Requirements
- R1: A frame holds `cfg_frame_words_m1`+1 word slots. After the last bit of the last slot, the next tick starts slot 0 bit 0 again. Frame length in bits is (w0+1)+`cfg_frame_words_m1`*(wn+1), where w0 is `cfg_w0_bits_m1` and wn is `cfg_wn_bits_m1`.
- R2: Slot 0 lasts `cfg_w0_bits_m1`+1 bit periods and every other slot lasts `cfg_wn_bits_m1`+1 bit periods. Both field values must be at least 7, so a slot holds 8 to 32 bits.
- R3: The sync is active during the first `cfg_sync_len_m1`+1 bit periods of slot 0. `cfg_sync_len_m1` must not exceed `cfg_w0_bits_m1`. The active level is 1 when `cfg_sync_low`=0 and 0 when `cfg_sync_low`=1.
- R4: With `cfg_sync_early`=1, the sync window moves one bit period earlier. It starts on the last bit of the preceding frame and keeps the same length.
- R5: Bit k of a slot (k=0 first) is data[F-k] when `cfg_msb_first`=1 and data[F+k] when it is 0, where F is `cfg_first_bit`. An index outside 0..31 sends 0.
- R6: When bit i of `cfg_slot_mask` is 1, slot i takes no word (`in_ready` stays 0), `sd_en` is 0 and `sd_out` is 0 for the whole slot.
- R7: `in_ready` is 1 exactly in the clock cycle where `bit_tick` is 1 and the next bit position is bit 0 of an unmasked slot. A word is consumed when `in_valid` is also 1.
- R8: An unmasked slot that starts while `in_valid` is 0 sends zeros with `sd_en`=1 and sets `underrun_err`. `underrun_err` stays 1 until reset.
- R9: `word_start` is 1 during the first bit period of slot number `cfg_mark_word` (counted from 0) and is 0 at all other times.
- R10: `sd_out`, `sd_en`, `word_start` and the active state of the sync change only one clock after an edge that samples `bit_tick`=1. They hold their values in every other cycle.
- R11: Reset (synchronous, `rst_n`=0) sets `sd_out`, `sd_en`, `word_start` and `underrun_err` to 0, drives the sync at its inactive level and returns the frame position to slot 0 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | Advance one bit position in this cycle |
| in_valid | input | 1 | Input word available |
| in_data | input | DATA_W | Input audio word |
| in_ready | output | 1 | Word taken in this cycle when in_valid is 1 |
| cfg_frame_words_m1 | input | log2(MAX_WORDS) | Slots per frame minus 1 |
| cfg_sync_len_m1 | input | log2(DATA_W) | Sync length in bit periods minus 1 |
| cfg_w0_bits_m1 | input | log2(DATA_W) | Slot 0 width minus 1 |
| cfg_wn_bits_m1 | input | log2(DATA_W) | Width of other slots minus 1 |
| cfg_msb_first | input | 1 | 1: descending bit order, 0: ascending |
| cfg_sync_low | input | 1 | 1: sync active low |
| cfg_sync_early | input | 1 | 1: sync leads the frame by one bit |
| cfg_slot_mask | input | MAX_WORDS | One silence bit per slot |
| cfg_first_bit | input | log2(DATA_W) | Data bit sent first in each slot |
| cfg_mark_word | input | log2(MAX_WORDS) | Slot flagged by word_start |
| sd_out | output | 1 | Serial data |
| sd_en | output | 1 | Serial data carries a slot's data |
| fsync | output | 1 | Frame sync |
| word_start | output | 1 | First bit of the marked slot |
| underrun_err | output | 1 | Sticky missing-word error |

## Verification
`in_ready` is combinational and is due in the same cycle as the tick that opens a slot. The bench reads it 1 ns after it raises `bit_tick` and before the clock edge. Every serial output and the flags come from a single register stage, so they are due one clock after the edge that sampled the tick. The bench compares them at the following falling edge and compares them again one clock later with no tick to confirm they hold. A bench-side position model computes each expected bit, the sync window and the consumed words from the configuration alone.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
   localparam int MIN_SLOT_BITS = 8;

   typedef enum logic {
      ORDER_ASCENDING  = 1'b0,
      ORDER_DESCENDING = 1'b1
   } bit_order_e;
endpackage

// File: rtl/tdm_slot_seq.sv
// Tracks the slot and bit position inside the frame and offers the
// position that the next tick will move to.
module tdm_slot_seq #(
   parameter int IW = 4,
   parameter int BW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   input  logic [IW-1:0] frame_m1,
   input  logic [BW-1:0] w0_m1,
   input  logic [BW-1:0] wn_m1,
   output logic [IW-1:0] slot_idx,
   output logic [BW-1:0] bit_idx,
   output logic [IW-1:0] nxt_slot,
   output logic [BW-1:0] nxt_bit
);
   logic [BW-1:0] width_m1;
   logic          last_bit;
   logic          last_slot;

   always_comb begin
      width_m1  = (slot_idx == '0) ? w0_m1 : wn_m1;
      last_bit  = (bit_idx >= width_m1);
      last_slot = (slot_idx >= frame_m1);
      nxt_bit   = last_bit ? '0 : bit_idx + 1'b1;
      if (!last_bit)
         nxt_slot = slot_idx;
      else if (last_slot)
         nxt_slot = '0;
      else
         nxt_slot = slot_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_idx <= '0;
         bit_idx  <= '0;
      end else if (advance) begin
         slot_idx <= nxt_slot;
         bit_idx  <= nxt_bit;
      end
   end
endmodule

// File: rtl/tdm_sync_gen.sv
// Decides whether the sync window covers the bit about to be sent.
module tdm_sync_gen #(
   parameter int IW = 4,
   parameter int BW = 5
) (
   input  logic [IW-1:0] cur_slot,
   input  logic [BW-1:0] cur_bit,
   input  logic [IW-1:0] nxt_slot,
   input  logic [BW-1:0] nxt_bit,
   input  logic [BW-1:0] len_m1,
   input  logic          early,
   output logic          active
);
   logic in_cur;
   logic in_nxt;

   always_comb begin
      in_cur = (cur_slot == '0) && (cur_bit <= len_m1);
      in_nxt = (nxt_slot == '0) && (nxt_bit <= len_m1);
      active = early ? in_nxt : in_cur;
   end
endmodule

// File: rtl/tdm_bit_pick.sv
// Selects the data bit for slot position k from the first-bit index.
module tdm_bit_pick #(
   parameter int DATA_W    = 32,
   parameter bit ALLOW_ASC = 1'b1
) (
   input  logic [DATA_W-1:0]         word,
   input  logic [$clog2(DATA_W)-1:0] first,
   input  logic [$clog2(DATA_W)-1:0] k,
   input  logic                      descending,
   output logic                      bit_o
);
   localparam int BW = $clog2(DATA_W);

   logic [BW:0] diff;
   logic        desc_bit;

   always_comb begin
      diff     = {1'b0, first} - {1'b0, k};
      desc_bit = diff[BW] ? 1'b0 : word[diff[BW-1:0]];
   end

   if (ALLOW_ASC) begin : g_both_orders
      logic [BW:0] sum;
      logic        asc_bit;
      always_comb begin
         sum     = {1'b0, first} + {1'b0, k};
         asc_bit = sum[BW] ? 1'b0 : word[sum[BW-1:0]];
         bit_o   = descending ? desc_bit : asc_bit;
      end
   end else begin : g_desc_only
      logic unused_order;
      assign unused_order = descending;
      assign bit_o        = desc_bit;
   end
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
   import tdm_tx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MAX_WORDS = 16,
   parameter bit ALLOW_ASC = 1'b1,
   localparam int IW       = $clog2(MAX_WORDS),
   localparam int BW       = $clog2(DATA_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_tick,
   input  logic                 in_valid,
   input  logic [DATA_W-1:0]    in_data,
   output logic                 in_ready,
   input  logic [IW-1:0]        cfg_frame_words_m1,
   input  logic [BW-1:0]        cfg_sync_len_m1,
   input  logic [BW-1:0]        cfg_w0_bits_m1,
   input  logic [BW-1:0]        cfg_wn_bits_m1,
   input  logic                 cfg_msb_first,
   input  logic                 cfg_sync_low,
   input  logic                 cfg_sync_early,
   input  logic [MAX_WORDS-1:0] cfg_slot_mask,
   input  logic [BW-1:0]        cfg_first_bit,
   input  logic [IW-1:0]        cfg_mark_word,
   output logic                 sd_out,
   output logic                 sd_en,
   output logic                 fsync,
   output logic                 word_start,
   output logic                 underrun_err
);
   if (DATA_W < MIN_SLOT_BITS || (1 << BW) != DATA_W) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 8");
   end
   if (MAX_WORDS < 2 || (1 << IW) != MAX_WORDS) begin : g_bad_depth
      $error("MAX_WORDS must be a power of two of at least 2");
   end

   logic [IW-1:0]     slot_idx, nxt_slot;
   logic [BW-1:0]     bit_idx, nxt_bit;
   logic              sync_act;
   logic              slot_first;
   logic              slot_masked;
   logic              take;
   logic [DATA_W-1:0] fresh_word;
   logic [DATA_W-1:0] src_word;
   logic [DATA_W-1:0] hold_q;
   logic              pick;
   logic              sd_q, en_q, fs_q, ws_q, under_q;

   tdm_slot_seq #(.IW(IW), .BW(BW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (bit_tick),
      .frame_m1 (cfg_frame_words_m1),
      .w0_m1    (cfg_w0_bits_m1),
      .wn_m1    (cfg_wn_bits_m1),
      .slot_idx (slot_idx),
      .bit_idx  (bit_idx),
      .nxt_slot (nxt_slot),
      .nxt_bit  (nxt_bit)
   );

   tdm_sync_gen #(.IW(IW), .BW(BW)) u_sync (
      .cur_slot (slot_idx),
      .cur_bit  (bit_idx),
      .nxt_slot (nxt_slot),
      .nxt_bit  (nxt_bit),
      .len_m1   (cfg_sync_len_m1),
      .early    (cfg_sync_early),
      .active   (sync_act)
   );

   always_comb begin
      slot_first  = (bit_idx == '0);
      slot_masked = cfg_slot_mask[slot_idx];
      take        = slot_first && !slot_masked;
      in_ready    = bit_tick && take;
      fresh_word  = (take && in_valid) ? in_data : '0;
      src_word    = slot_first ? fresh_word : hold_q;
   end

   tdm_bit_pick #(.DATA_W(DATA_W), .ALLOW_ASC(ALLOW_ASC)) u_pick (
      .word       (src_word),
      .first      (cfg_first_bit),
      .k          (bit_idx),
      .descending (cfg_msb_first),
      .bit_o      (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_q    <= 1'b0;
         en_q    <= 1'b0;
         fs_q    <= 1'b0;
         ws_q    <= 1'b0;
         under_q <= 1'b0;
         hold_q  <= '0;
      end else if (bit_tick) begin
         sd_q <= slot_masked ? 1'b0 : pick;
         en_q <= !slot_masked;
         fs_q <= sync_act;
         ws_q <= slot_first && (slot_idx == cfg_mark_word);
         if (slot_first)
            hold_q <= fresh_word;
         if (take && !in_valid)
            under_q <= 1'b1;
      end
   end

   assign sd_out       = sd_q;
   assign sd_en        = en_q;
   assign fsync        = fs_q ^ cfg_sync_low;
   assign word_start   = ws_q;
   assign underrun_err = under_q;
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk #(
   parameter int DATA_W    = 32,
   parameter int MAX_WORDS = 16,
   localparam int BW       = $clog2(DATA_W)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_tick,
   input logic          in_valid,
   input logic          in_ready,
   input logic [BW-1:0] cfg_sync_len_m1,
   input logic [BW-1:0] cfg_w0_bits_m1,
   input logic [BW-1:0] cfg_wn_bits_m1,
   input logic          sd_out,
   input logic          sd_en,
   input logic          word_start,
   input logic          underrun_err
);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_tick) |-> ($stable(sd_out) && $stable(sd_en) && $stable(word_start)));

   assert_ready_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_tick);

   assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_en |-> !sd_out);

   assert_underrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> underrun_err);

   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_err |=> underrun_err);

   assert_sync_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sync_len_m1 <= cfg_w0_bits_m1);

   assert_width_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_w0_bits_m1 >= 7) && (cfg_wn_bits_m1 >= 7));
endmodule

bind tdm_frame_tx tdm_frame_tx_chk #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bit_tick        (bit_tick),
   .in_valid        (in_valid),
   .in_ready        (in_ready),
   .cfg_sync_len_m1 (cfg_sync_len_m1),
   .cfg_w0_bits_m1  (cfg_w0_bits_m1),
   .cfg_wn_bits_m1  (cfg_wn_bits_m1),
   .sd_out          (sd_out),
   .sd_en           (sd_en),
   .word_start      (word_start),
   .underrun_err    (underrun_err)
);

// File: tb/sim_tdm_frame_tx.sv
`timescale 1ns/1ps
module sim_tdm_frame_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic [3:0]  cfg_frame_words_m1 = 4'd1;
   logic [4:0]  cfg_sync_len_m1 = 5'd0;
   logic [4:0]  cfg_w0_bits_m1 = 5'd15;
   logic [4:0]  cfg_wn_bits_m1 = 5'd15;
   logic        cfg_msb_first = 1'b1;
   logic        cfg_sync_low = 1'b0;
   logic        cfg_sync_early = 1'b0;
   logic [15:0] cfg_slot_mask = '0;
   logic [4:0]  cfg_first_bit = 5'd15;
   logic [3:0]  cfg_mark_word = 4'd0;
   logic        sd_out, sd_en, fsync, word_start, underrun_err;

   int n_chk = 0;
   int n_bad = 0;

   // bench-side frame model
   int          m_slot, m_bit;
   logic [31:0] m_word;
   logic        m_under;
   logic [31:0] feed [0:15];
   int          feed_n, feed_ptr;

   always #2.5 clk = ~clk;

   tdm_frame_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready),
      .cfg_frame_words_m1(cfg_frame_words_m1), .cfg_sync_len_m1(cfg_sync_len_m1),
      .cfg_w0_bits_m1(cfg_w0_bits_m1), .cfg_wn_bits_m1(cfg_wn_bits_m1),
      .cfg_msb_first(cfg_msb_first), .cfg_sync_low(cfg_sync_low),
      .cfg_sync_early(cfg_sync_early), .cfg_slot_mask(cfg_slot_mask),
      .cfg_first_bit(cfg_first_bit), .cfg_mark_word(cfg_mark_word),
      .sd_out(sd_out), .sd_en(sd_en), .fsync(fsync), .word_start(word_start),
      .underrun_err(underrun_err)
   );

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
      end
   endtask

   function automatic logic model_bit(logic [31:0] w, int k);
      int idx;
      idx = cfg_msb_first ? int'(cfg_first_bit) - k : int'(cfg_first_bit) + k;
      if (idx < 0 || idx > 31) return 1'b0;
      return w[idx];
   endfunction

   function automatic logic model_sync();
      int w0, wn, fb, p, q;
      w0 = int'(cfg_w0_bits_m1) + 1;
      wn = int'(cfg_wn_bits_m1) + 1;
      fb = w0 + int'(cfg_frame_words_m1) * wn;
      p  = (m_slot == 0) ? m_bit : w0 + (m_slot - 1) * wn + m_bit;
      q  = cfg_sync_early ? (p + 1) % fb : p;
      return (q <= int'(cfg_sync_len_m1)) ^ cfg_sync_low;
   endfunction

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_tick = 1'b0; in_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_slot = 0; m_bit = 0; m_word = '0; m_under = 1'b0; feed_ptr = 0;
   endtask

   // One bit period: tick for one clock, check, then one idle clock, check again.
   task automatic do_tick();
      int   width;
      logic first, masked, e_sd, e_fs, e_ws;
      width  = (m_slot == 0) ? int'(cfg_w0_bits_m1) + 1 : int'(cfg_wn_bits_m1) + 1;
      first  = (m_bit == 0);
      masked = cfg_slot_mask[m_slot];
      @(negedge clk);
      bit_tick = 1'b1;
      in_valid = (feed_ptr < feed_n);
      in_data  = in_valid ? feed[feed_ptr] : 32'h0;
      #1;
      chk(in_ready, first && !masked, masked ? "R6 in_ready in masked slot" : "R7 in_ready");
      if (first && !masked) begin
         if (in_valid) begin
            m_word = feed[feed_ptr];
            feed_ptr++;
         end else begin
            m_word  = '0;
            m_under = 1'b1;
         end
      end
      e_sd = masked ? 1'b0 : model_bit(m_word, m_bit);
      e_fs = model_sync();
      e_ws = first && (m_slot == int'(cfg_mark_word));
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
      in_valid = 1'b0;
      #1;
      chk(sd_out, e_sd, "R5 sd_out");
      chk(sd_en, !masked, "R6 sd_en");
      chk(fsync, e_fs, cfg_sync_early ? "R4 fsync" : "R3 fsync");
      chk(word_start, e_ws, "R9 word_start");
      chk(underrun_err, m_under, "R8 underrun_err");
      @(posedge clk);
      #1;
      chk(sd_out, e_sd, "R10 sd_out hold");
      chk(sd_en, !masked, "R10 sd_en hold");
      chk(word_start, e_ws, "R10 word_start hold");
      if (m_bit == width - 1) begin
         m_bit  = 0;
         m_slot = (m_slot >= int'(cfg_frame_words_m1)) ? 0 : m_slot + 1;
      end else begin
         m_bit++;
      end
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask

   task automatic t_reset();
      cfg_sync_low = 1'b1;
      apply_reset();
      #1;
      chk(sd_out, 1'b0, "R11 sd_out reset");
      chk(sd_en, 1'b0, "R11 sd_en reset");
      chk(fsync, 1'b1, "R11 fsync idle level");
      chk(word_start, 1'b0, "R11 word_start reset");
      chk(underrun_err, 1'b0, "R11 underrun reset");
      chk(in_ready, 1'b0, "R11 in_ready idle");
   endtask

   task automatic t_stereo();
      // R1 R2 R3: two 16-bit slots, 16-bit sync, descending from bit 15
      cfg_frame_words_m1 = 4'd1; cfg_w0_bits_m1 = 5'd15; cfg_wn_bits_m1 = 5'd15;
      cfg_sync_len_m1 = 5'd15; cfg_msb_first = 1'b1; cfg_first_bit = 5'd15;
      cfg_sync_low = 1'b0; cfg_sync_early = 1'b0; cfg_slot_mask = '0; cfg_mark_word = 4'd1;
      apply_reset();
      feed[0] = 32'h0000_A5C3; feed[1] = 32'h0000_1234;
      feed[2] = 32'hFFFF_8001; feed[3] = 32'h0000_7FFE; feed_n = 4;
      run_ticks(64);
      n_chk++;
      if (feed_ptr != 4) begin
         n_bad++;
         $display("FAIL R1 words consumed in two frames: got %0d expected 4", feed_ptr);
      end
   endtask

   task automatic t_mixed();
      // R2 R4 R5: 12-bit slot 0, 8-bit others, ascending, early one-bit active-low sync
      cfg_frame_words_m1 = 4'd3; cfg_w0_bits_m1 = 5'd11; cfg_wn_bits_m1 = 5'd7;
      cfg_sync_len_m1 = 5'd0; cfg_msb_first = 1'b0; cfg_first_bit = 5'd0;
      cfg_sync_low = 1'b1; cfg_sync_early = 1'b1; cfg_slot_mask = '0; cfg_mark_word = 4'd3;
      apply_reset();
      for (int i = 0; i < 8; i++) feed[i] = 32'h9E37_79B9 * (i + 3);
      feed_n = 8;
      run_ticks(72);
   endtask

   task automatic t_mask();
      // R6: slots 1 and 3 silent
      cfg_frame_words_m1 = 4'd3; cfg_w0_bits_m1 = 5'd7; cfg_wn_bits_m1 = 5'd7;
      cfg_sync_len_m1 = 5'd3; cfg_msb_first = 1'b1; cfg_first_bit = 5'd7;
      cfg_sync_low = 1'b0; cfg_sync_early = 1'b0; cfg_slot_mask = 16'b1010; cfg_mark_word = 4'd2;
      apply_reset();
      feed[0] = 32'hC3; feed[1] = 32'h5A; feed[2] = 32'hFF; feed[3] = 32'h81; feed_n = 4;
      run_ticks(64);
      n_chk++;
      if (feed_ptr != 4) begin
         n_bad++;
         $display("FAIL R6 words consumed with mask: got %0d expected 4", feed_ptr);
      end
   endtask

   task automatic t_shift();
      // R5 R9: 24-bit slots taken from the top of the word
      cfg_frame_words_m1 = 4'd2; cfg_w0_bits_m1 = 5'd23; cfg_wn_bits_m1 = 5'd23;
      cfg_sync_len_m1 = 5'd23; cfg_msb_first = 1'b1; cfg_first_bit = 5'd31;
      cfg_sync_low = 1'b0; cfg_sync_early = 1'b0; cfg_slot_mask = '0; cfg_mark_word = 4'd2;
      apply_reset();
      feed[0] = 32'hDEAD_BEEF; feed[1] = 32'h0123_4567; feed[2] = 32'hF0F0_0F0F; feed_n = 3;
      run_ticks(72);
   endtask

   task automatic t_underrun();
      // R8 R5: one word for two frames; ascending from bit 28 runs past bit 31
      cfg_frame_words_m1 = 4'd1; cfg_w0_bits_m1 = 5'd7; cfg_wn_bits_m1 = 5'd7;
      cfg_sync_len_m1 = 5'd1; cfg_msb_first = 1'b0; cfg_first_bit = 5'd28;
      cfg_sync_low = 1'b0; cfg_sync_early = 1'b0; cfg_slot_mask = '0; cfg_mark_word = 4'd0;
      apply_reset();
      feed[0] = 32'hB000_0000; feed_n = 1;
      run_ticks(32);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      feed_n = 0;
      t_reset();
      t_stereo();
      t_mixed();
      t_mask();
      t_shift();
      t_underrun();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule